// File: doc/BRIEF.md
# Serial Flash Status Register Write Controller

This block is the slave-side command unit that owns the status register of a serial flash device. It watches chip select, serial clock and serial data in from an SPI master (mode 0), decodes three one-byte commands, and drives serial data out. The commands are: arm writes, read status, and write status. The serial lines are resynchronised into the system clock domain, so the SPI clock must be slow compared with the system clock.

A status write is a two-byte frame, the command followed by one data byte. It is honoured only when several conditions hold: the write-enable latch was armed beforehand, chip select rises exactly on a byte boundary, and the register is not locked by hardware protection. An accepted write starts a self-timed busy period of a fixed number of system clocks. The register can be polled throughout that period. At the end of the period the new protection settings take effect and the write-enable latch drops. The three block-protect bits are exported so that array operations elsewhere in the device can be gated.

Top module: `spi_status_ctrl`

## Requirements
- R1: After reset the status register reads 0x00 and the block-protect output is 0.
- R2: The arm command (code 0x06) sets the write-enable latch (status bit 1) only if chip select rises after exactly 8 clocked bits. A frame of 7 or 9 bits leaves the latch unchanged.
- R3: The read command (code 0x05) returns the status byte MSB first, changing on falling SCK. The layout is bit 7 lock bit, bits 6:5 always 0, bits 4:2 block-protect, bit 1 write-enable latch, bit 0 busy. The byte repeats for as long as chip select stays low.
- R4: A write command (code 0x01) plus one data byte, with chip select rising after exactly 16 bits and the latch set, raises the busy bit for WR_CYCLES system clocks.
- R5: A write frame that ends after any bit count other than 16 changes nothing and starts no busy period.
- R6: A write frame sent while the write-enable latch is clear changes nothing.
- R7: When the busy period ends, the lock bit takes data bit 7 and the block-protect bits take data bits 4:2, and the write-enable latch is cleared. Data bits 6, 5, 1 and 0 have no effect. Until that point the old values are read back.
- R8: While the lock bit is 1 and the write-protect pin is low, write frames are not executed. With the pin high, the register is writable again.
- R9: While busy, arm and write commands are ignored, and the read command still works.
- R10: The block-protect output always equals status bits 4:2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | SPI chip select, active low |
| sck | input | 1 | SPI serial clock (mode 0) |
| mosi | input | 1 | Serial data from master |
| wp_n | input | 1 | Write-protect pin, active low |
| miso | output | 1 | Serial data to master |
| bp_o | output | 3 | Block-protect bits for array gating |

## Verification
The assertions assume a well-formed mode 0 master. Chip select moves only while SCK is low, and every SCK phase and every chip select gap lasts several system clocks, so each edge survives the two-stage synchroniser as one clean pulse. The write-protect pin is also assumed to stay steady around a frame's closing edge. The stimulus keeps to these limits: it uses ten system clocks per SCK half period, changes data only while SCK is low, and changes the write-protect pin only between frames. It samples serial data out just before each rising SCK edge.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam logic [7:0] CMD_ARM  = 8'h06;
  localparam logic [7:0] CMD_WRST = 8'h01;
  localparam logic [7:0] CMD_RDST = 8'h05;
  localparam int unsigned CMD_BITS   = 8;
  localparam int unsigned FRAME_BITS = 16;

  // packed status image (bit 7 lock, 6:5 zero, 4:2 protect, 1 latch, 0 busy)
  function automatic logic [7:0] pack_status(input logic lock, input logic [2:0] prot,
                                             input logic arm, input logic busy);
    return {lock, 2'b00, prot, arm, busy};
  endfunction
endpackage

// File: rtl/spi_in_sync.sv
module spi_in_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_i,
  input  logic [WIDTH-1:0] idle_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [WIDTH-1:0] d;
    if (s == 0) begin : g_first
      assign d = raw_i;
    end else begin : g_next
      assign d = stage_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= idle_i;
      else        stage_q[s] <= d;
    end
  end

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_s,
  input  logic       sck_s,
  input  logic       mosi_s,
  input  logic [7:0] status_i,
  input  logic       busy_i,
  input  logic       arm_i,
  input  logic       locked_i,
  output logic       arm_go_o,
  output logic       wr_go_o,
  output logic [3:0] wr_bits_o,
  output logic       miso_o
);
  localparam int unsigned CNT_MAX = FRAME_BITS + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic             sck_q, cs_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [2:0]       pos_q, pos_n;
  logic [7:0]       sh_q, sh_n, cmd_q, cmd_n, tx_q, tx_n;
  logic [3:0]       dat_q, dat_n;
  logic             rd_q, rd_n;
  logic             sck_rise, sck_fall, cs_rise;
  logic [7:0]       in_byte;

  assign sck_rise = sck_s & ~sck_q;
  assign sck_fall = ~sck_s & sck_q;
  assign cs_rise  = cs_s & ~cs_q;
  assign in_byte  = {sh_q[6:0], mosi_s};

  always_comb begin
    cnt_n = cnt_q;
    pos_n = pos_q;
    sh_n  = sh_q;
    cmd_n = cmd_q;
    dat_n = dat_q;
    rd_n  = rd_q;
    tx_n  = tx_q;
    if (cs_s) begin
      cnt_n = '0;
      pos_n = '0;
      rd_n  = 1'b0;
    end else begin
      if (sck_rise) begin
        sh_n  = in_byte;
        pos_n = pos_q + 3'd1;
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_n = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(CMD_BITS - 1)) begin
          cmd_n = in_byte;
          rd_n  = (in_byte == CMD_RDST);
        end
        if (cnt_q == CNT_W'(FRAME_BITS - 1)) dat_n = {sh_q[6], sh_q[3:1]};
      end
      if (sck_fall && rd_q) begin
        if (pos_q == 3'd0) tx_n = status_i;
        else               tx_n = {tx_q[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      cs_q  <= 1'b1;
      cnt_q <= '0;
      pos_q <= '0;
      sh_q  <= '0;
      cmd_q <= '0;
      dat_q <= '0;
      rd_q  <= 1'b0;
      tx_q  <= '0;
    end else begin
      sck_q <= sck_s;
      cs_q  <= cs_s;
      cnt_q <= cnt_n;
      pos_q <= pos_n;
      sh_q  <= sh_n;
      cmd_q <= cmd_n;
      dat_q <= dat_n;
      rd_q  <= rd_n;
      tx_q  <= tx_n;
    end
  end

  // count is still the frame's own value in the cycle chip select rise is seen
  assign arm_go_o  = cs_rise && !busy_i && (cnt_q == CNT_W'(CMD_BITS)) && (cmd_q == CMD_ARM);
  assign wr_go_o   = cs_rise && !busy_i && arm_i && !locked_i &&
                     (cnt_q == CNT_W'(FRAME_BITS)) && (cmd_q == CMD_WRST);
  assign wr_bits_o = dat_q;
  assign miso_o    = rd_q & tx_q[7];
endmodule

// File: rtl/wr_cycle_timer.sv
module wr_cycle_timer #(
  parameter int unsigned CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned TW = $clog2(CYCLES + 1);

  logic          busy_q, busy_n;
  logic [TW-1:0] left_q, left_n;

  assign done_o = busy_q && (left_q == '0);

  always_comb begin
    busy_n = busy_q;
    left_n = left_q;
    if (start_i && !busy_q) begin
      busy_n = 1'b1;
      left_n = TW'(CYCLES - 1);
    end else if (done_o) begin
      busy_n = 1'b0;
    end else if (busy_q) begin
      left_n = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      left_q <= '0;
    end else begin
      busy_q <= busy_n;
      left_q <= left_n;
    end
  end

  assign busy_o = busy_q;
endmodule

// File: rtl/stat_reg_file.sv
module stat_reg_file
  import spi_stat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm_go_i,
  input  logic       wr_go_i,
  input  logic [3:0] wr_bits_i,
  input  logic       wp_s,
  input  logic       busy_i,
  input  logic       done_i,
  output logic       arm_o,
  output logic       lock_o,
  output logic [2:0] prot_o,
  output logic       locked_o,
  output logic [7:0] status_o
);
  logic       arm_q, arm_n;
  logic       lock_q, lock_n;
  logic [2:0] prot_q, prot_n;
  logic [3:0] pend_q, pend_n;

  always_comb begin
    arm_n  = arm_q;
    lock_n = lock_q;
    prot_n = prot_q;
    pend_n = pend_q;
    if (arm_go_i) arm_n = 1'b1;
    if (wr_go_i)  pend_n = wr_bits_i;
    if (done_i) begin
      lock_n = pend_q[3];
      prot_n = pend_q[2:0];
      arm_n  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q  <= 1'b0;
      lock_q <= 1'b0;
      prot_q <= '0;
      pend_q <= '0;
    end else begin
      arm_q  <= arm_n;
      lock_q <= lock_n;
      prot_q <= prot_n;
      pend_q <= pend_n;
    end
  end

  assign arm_o    = arm_q;
  assign lock_o   = lock_q;
  assign prot_o   = prot_q;
  assign locked_o = lock_q & ~wp_s;
  assign status_o = pack_status(lock_q, prot_q, arm_q, busy_i);
endmodule

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl #(
  parameter int unsigned WR_CYCLES   = 200,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       sck,
  input  logic       mosi,
  input  logic       wp_n,
  output logic       miso,
  output logic [2:0] bp_o
);
  logic [1:0] rst_pipe;
  logic       rst_ns;
  logic [3:0] syn;
  logic       wip, wel, srwd, hpm, done;
  logic [2:0] bp;
  logic       wren_go, wrsr_go;
  logic [3:0] wr_bits;
  logic [7:0] status;

  // reset asserts at once, releases on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ns = rst_pipe[1];

  spi_in_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_ns),
    .raw_i({wp_n, mosi, sck, cs_n}),
    .idle_i(4'b1001),
    .sync_o(syn)
  );

  spi_frame_ctrl frame_i (
    .clk(clk), .rst_n(rst_ns),
    .cs_s(syn[0]), .sck_s(syn[1]), .mosi_s(syn[2]),
    .status_i(status), .busy_i(wip), .arm_i(wel), .locked_i(hpm),
    .arm_go_o(wren_go), .wr_go_o(wrsr_go), .wr_bits_o(wr_bits), .miso_o(miso)
  );

  wr_cycle_timer #(.CYCLES(WR_CYCLES)) timer_i (
    .clk(clk), .rst_n(rst_ns), .start_i(wrsr_go), .busy_o(wip), .done_o(done)
  );

  stat_reg_file regs_i (
    .clk(clk), .rst_n(rst_ns),
    .arm_go_i(wren_go), .wr_go_i(wrsr_go), .wr_bits_i(wr_bits),
    .wp_s(syn[3]), .busy_i(wip), .done_i(done),
    .arm_o(wel), .lock_o(srwd), .prot_o(bp), .locked_o(hpm), .status_o(status)
  );

  assign bp_o = bp;
endmodule

// File: rtl/spi_status_ctrl_chk.sv
module spi_status_ctrl_chk (
  input logic       clk,
  input logic       rst_ns,
  input logic       wip,
  input logic       wel,
  input logic       srwd,
  input logic [2:0] bp,
  input logic       hpm,
  input logic       wren_go
);
  // R4: a busy period only begins with the latch armed
  p_busy_needs_latch_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(wip) |-> wel);

  // R7: latch is clear once the busy period ends
  p_latch_drop_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    $fell(wip) |-> !wel);

  // R7: lock and protect bits move only at the end of a busy period
  p_prot_commit_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    !$fell(wip) |-> ($stable(bp) && $stable(srwd)));

  // R8: no busy period starts while hardware-locked
  p_no_write_locked_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(wip) |-> !$past(hpm));

  // R2: latch rises only after an accepted arm command
  p_latch_source_r2: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(wel) |-> $past(wren_go));
endmodule

bind spi_status_ctrl spi_status_ctrl_chk chk_i (
  .clk(clk), .rst_ns(rst_ns), .wip(wip), .wel(wel), .srwd(srwd),
  .bp(bp), .hpm(hpm), .wren_go(wren_go)
);

// File: tb/spi_status_ctrl_tb_top.sv
module spi_status_ctrl_tb_top;
  localparam int HALF = 10;
  localparam int CYC  = 1000;

  typedef struct {
    logic [7:0] val;
    string      tag;
  } exp_t;

  logic clk, rst_n, cs_n, sck, mosi, wp_n;
  logic       miso;
  logic [2:0] bp_o;

  exp_t       exp_q[$];
  logic [7:0] act_q[$];
  int checks = 0;
  int bad    = 0;
  bit done   = 0;

  spi_status_ctrl #(.WR_CYCLES(CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .wp_n(wp_n), .miso(miso), .bp_o(bp_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [31:0] v, input int n, output logic [31:0] rx);
    rx = '0;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = v[i];
      idle(HALF);
      rx = {rx[30:0], miso};
      sck = 1'b1;
      idle(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic frame(input logic [31:0] v, input int n);
    logic [31:0] rx;
    cs_n = 1'b0;
    idle(HALF);
    shift_bits(v, n, rx);
    idle(HALF);
    cs_n = 1'b1;
    idle(3 * HALF);
  endtask

  // driver: expected bytes go to the scoreboard, observed bytes to the monitor
  task automatic read_status(input int nbytes, input logic [7:0] e, input string tag);
    logic [31:0] rx;
    for (int k = 0; k < nbytes; k++) exp_q.push_back('{val: e, tag: tag});
    cs_n = 1'b0;
    idle(HALF);
    shift_bits(32'h05, 8, rx);
    for (int k = 0; k < nbytes; k++) begin
      shift_bits(32'h0, 8, rx);
      act_q.push_back(rx[7:0]);
    end
    idle(HALF);
    cs_n = 1'b1;
    idle(3 * HALF);
  endtask

  task automatic check_bp(input logic [2:0] e, input string tag);
    checks++;
    if (bp_o !== e) begin
      bad++;
      $display("FAIL %s bp_o actual=%0h expected=%0h", tag, bp_o, e);
    end
  endtask

  // monitor
  initial begin
    forever begin
      logic [7:0] a;
      exp_t       e;
      wait (act_q.size() > 0);
      a = act_q.pop_front();
      e = exp_q.pop_front();
      checks++;
      if (a !== e.val) begin
        bad++;
        $display("FAIL %s status actual=%02h expected=%02h", e.tag, a, e.val);
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; mosi = 1'b0; wp_n = 1'b1;
    idle(10);
    rst_n = 1'b1;
    idle(10);

    check_bp(3'd0, "R1");
    read_status(1, 8'h00, "R1");

    frame(32'h03, 7);                 // R2: 7-bit arm frame
    read_status(1, 8'h00, "R2 short");
    frame(32'h0C, 9);                 // R2: 9-bit arm frame
    read_status(1, 8'h00, "R2 long");
    frame(32'h06, 8);
    read_status(2, 8'h02, "R2 R3 stream");

    frame(32'h00FF, 15);              // R5: write frame one bit short
    read_status(1, 8'h02, "R5 short");
    frame(32'h203FE, 17);             // R5: write frame one bit long
    read_status(1, 8'h02, "R5 long");

    frame(32'h01FF, 16);              // R4: accepted write
    read_status(1, 8'h03, "R4 R9 busy read");
    frame(32'h0100, 16);              // R9: ignored while busy
    idle(CYC + 100);
    read_status(1, 8'h9C, "R7 commit");
    check_bp(3'd7, "R10");

    wp_n = 1'b0;
    idle(10);
    frame(32'h06, 8);
    read_status(1, 8'h9E, "R8 arm");
    frame(32'h0100, 16);              // R8: locked
    read_status(1, 8'h9E, "R8 locked");
    idle(CYC + 100);
    read_status(1, 8'h9E, "R8 unchanged");

    wp_n = 1'b1;
    idle(10);
    frame(32'h0100, 16);              // R8: pin high unlocks
    read_status(1, 8'h9F, "R8 unlocked busy");
    idle(CYC + 100);
    read_status(1, 8'h00, "R8 R7 cleared");
    check_bp(3'd0, "R10 cleared");

    frame(32'h011C, 16);              // R6: latch clear
    read_status(1, 8'h00, "R6");
    idle(CYC + 100);
    read_status(1, 8'h00, "R6 after");

    frame(32'h06, 8);
    frame(32'h01EB, 16);              // R7: bits 6,5,1,0 ignored
    read_status(1, 8'h03, "R4 second");
    idle(CYC + 100);
    read_status(1, 8'h88, "R7 masked bits");
    check_bp(3'd2, "R10 masked");

    idle(20);
    done = 1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule